// File: doc/BRIEF.md
# External Data Bus Cycle Controller

This block runs byte-wide reads and writes to external data memory for a small microcontroller core. It shares one 8-bit port between low address and data, and uses a second 8-bit port for the high address. The core raises a request and gives it four things: an address mode, a 16-bit address, a write byte and a direction. In narrow mode only the low address byte is used, as a register-indirect access does. In wide mode the full 16-bit pointer is used.

Each accepted request runs through four phases in order. In the address phase the address-latch strobe is high and the low address byte is on the shared port. In the hold phase the strobe falls while the address is still driven. In the transfer phase the active-low read or write strobe is asserted. In the closing phase the strobe is released and the block raises a one-clock done pulse. After that the block returns to idle. When no cycle is running, both ports pass through the core's general-purpose port latch values. In narrow mode the high port keeps that general-purpose role even during a cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: While idle, `lo_out` equals `gp_lo`, `hi_out` equals `gp_hi`, `lo_oe` is 1, `ale` is 0, `rd_n` and `wr_n` are 1 and `done` is 0. This also holds during reset.
- R2: A request accepted at a clock edge starts the address phase on the next clock. For ADDR_CYC clocks, `ale` is 1, `lo_out` carries `req_addr[7:0]` and `lo_oe` is 1. Then, for LATCH_CYC clocks, `ale` is 0 while the same address byte stays driven and both strobes stay high.
- R3: When `req_wide` is 0 at acceptance (narrow mode), `hi_out` follows the live `gp_hi` in every phase of the cycle.
- R4: When `req_wide` is 1 at acceptance (wide mode), `hi_out` carries `req_addr[15:8]` from the first address clock through the closing phase, whatever `gp_hi` does.
- R5: When `req_write` is 1 (a write), `wr_n` is 0 for DATA_CYC clocks with `lo_out` equal to the write byte and `lo_oe` equal to 1. In the closing clock, `wr_n` returns to 1 while the byte is still driven.
- R6: When `req_write` is 0 (a read), `lo_oe` is 0 for the whole transfer and closing phases, and `rd_n` is 0 for DATA_CYC clocks. `rdata` takes the value of `lo_in` at the clock edge that ends the transfer phase. It holds that value until the next read completes.
- R7: `rd_n` and `wr_n` are never 0 at the same time, and neither is 0 while `ale` is 1.
- R8: `done` is 1 for exactly one clock: the closing clock, which comes ADDR_CYC+LATCH_CYC+DATA_CYC+1 clocks after the accepting edge. The block is idle on the clock after it.
- R9: A request raised while a cycle is running is ignored. It neither changes the running cycle nor starts another one.
- R10: The lengths of the address, hold and transfer phases are set by the parameters ADDR_CYC, LATCH_CYC and DATA_CYC (each at least 1, default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request, taken only while idle |
| req_wide | input | 1 | 1 selects the 16-bit pointer mode, 0 the 8-bit register mode |
| req_write | input | 1 | 1 selects a write, 0 a read |
| req_addr | input | 16 | Cycle address; only bits 7:0 are used in narrow mode |
| req_wdata | input | 8 | Byte to write |
| gp_lo | input | 8 | General-purpose latch value for the shared port |
| gp_hi | input | 8 | General-purpose latch value for the high port |
| lo_in | input | 8 | Value read back from the shared port pins |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| lo_out | output | 8 | Shared address/data port output value |
| lo_oe | output | 1 | Output enable for the shared port |
| hi_out | output | 8 | High port output value |
| rdata | output | 8 | Last byte captured by a read |
| done | output | 1 | One-clock pulse marking the end of a cycle |

## Verification
The hardest situations to reach from the ports come from stimulus that changes while a cycle is already running. One is a second request arriving in mid-cycle. Another is the general-purpose high value changing while a narrow cycle holds the bus. The stimulus for every cycle keeps `req_valid` high through the address and hold phases with a different address, and moves `gp_hi` and `gp_lo` on every clock. This shows that the running cycle is left alone, while in narrow mode the high port keeps tracking the live value. The read pins carry the complement of the expected byte until the last transfer clock. A capture at any other edge would therefore show up as a wrong `rdata`. The sweep uses stretched phase lengths (2, 1, 3) over both modes, both directions and sixteen address patterns.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  parameter int XB_DW = 8;
  parameter int XB_AW = 16;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_DATA  = 3'd3,
    PH_END   = 3'd4
  } xbus_phase_e;

  typedef struct packed {
    logic             wide;
    logic             write;
    logic [XB_AW-1:0] addr;
    logic [XB_DW-1:0] wdata;
  } xbus_req_t;
endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_CYC  = 1,
  parameter int LATCH_CYC = 1,
  parameter int DATA_CYC  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output xbus_phase_e phase,
  output logic        last
);
  localparam int MAXC = (ADDR_CYC > LATCH_CYC)
                      ? ((ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC)
                      : ((LATCH_CYC > DATA_CYC) ? LATCH_CYC : DATA_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] A_LAST = CW'(ADDR_CYC - 1);
  localparam logic [CW-1:0] L_LAST = CW'(LATCH_CYC - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DATA_CYC - 1);

  xbus_phase_e   phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim;

  always_comb begin
    case (phase_q)
      PH_ADDR:  lim = A_LAST;
      PH_LATCH: lim = L_LAST;
      PH_DATA:  lim = D_LAST;
      default:  lim = '0;
    endcase
  end

  assign last = (cnt_q == lim);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) phase_d = PH_ADDR;
      end
      PH_ADDR: begin
        if (last) begin phase_d = PH_LATCH; cnt_d = '0; end
        else      cnt_d = cnt_q + CW'(1);
      end
      PH_LATCH: begin
        if (last) begin phase_d = PH_DATA; cnt_d = '0; end
        else      cnt_d = cnt_q + CW'(1);
      end
      PH_DATA: begin
        if (last) begin phase_d = PH_END; cnt_d = '0; end
        else      cnt_d = cnt_q + CW'(1);
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_en,
  input  xbus_req_t        req_d,
  output xbus_req_t        req_q,
  input  logic             rd_en,
  input  logic [XB_DW-1:0] rd_d,
  output logic [XB_DW-1:0] rd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end
endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
  import xbus_pkg::*;
(
  input  xbus_phase_e      phase,
  input  xbus_req_t        req,
  input  logic [XB_DW-1:0] gp_lo,
  input  logic [XB_DW-1:0] gp_hi,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [XB_DW-1:0] lo_out,
  output logic             lo_oe,
  output logic [XB_DW-1:0] hi_out,
  output logic             done
);
  logic [XB_DW-1:0] hi_cyc;

  assign hi_cyc = req.wide ? req.addr[XB_AW-1:XB_DW] : gp_hi;

  always_comb begin
    ale    = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    lo_out = gp_lo;
    lo_oe  = 1'b1;
    hi_out = gp_hi;
    done   = 1'b0;
    case (phase)
      PH_ADDR: begin
        ale    = 1'b1;
        lo_out = req.addr[XB_DW-1:0];
        hi_out = hi_cyc;
      end
      PH_LATCH: begin
        lo_out = req.addr[XB_DW-1:0];
        hi_out = hi_cyc;
      end
      PH_DATA: begin
        hi_out = hi_cyc;
        if (req.write) begin
          wr_n   = 1'b0;
          lo_out = req.wdata;
        end else begin
          rd_n   = 1'b0;
          lo_out = '0;
          lo_oe  = 1'b0;
        end
      end
      PH_END: begin
        hi_out = hi_cyc;
        done   = 1'b1;
        lo_out = req.write ? req.wdata : '0;
        lo_oe  = req.write;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_CYC  = 1,
  parameter int LATCH_CYC = 1,
  parameter int DATA_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wide,
  input  logic             req_write,
  input  logic [XB_AW-1:0] req_addr,
  input  logic [XB_DW-1:0] req_wdata,
  input  logic [XB_DW-1:0] gp_lo,
  input  logic [XB_DW-1:0] gp_hi,
  input  logic [XB_DW-1:0] lo_in,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic [XB_DW-1:0] lo_out,
  output logic             lo_oe,
  output logic [XB_DW-1:0] hi_out,
  output logic [XB_DW-1:0] rdata,
  output logic             done
);
  logic        rst_n_int;
  xbus_phase_e phase;
  logic        last;
  logic        start;
  logic        rd_en;
  xbus_req_t   req_d, req_q;
  logic        wide_q;

  xbus_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign start = req_valid && (phase == PH_IDLE);
  assign rd_en = (phase == PH_DATA) && last && !req_q.write;
  assign req_d = '{wide: req_wide, write: req_write, addr: req_addr, wdata: req_wdata};
  assign wide_q = req_q.wide;

  xbus_seq #(
    .ADDR_CYC  (ADDR_CYC),
    .LATCH_CYC (LATCH_CYC),
    .DATA_CYC  (DATA_CYC)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n_int),
    .start (start),
    .phase (phase),
    .last  (last)
  );

  xbus_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .req_en (start),
    .req_d  (req_d),
    .req_q  (req_q),
    .rd_en  (rd_en),
    .rd_d   (lo_in),
    .rd_q   (rdata)
  );

  xbus_pads u_pads (
    .phase  (phase),
    .req    (req_q),
    .gp_lo  (gp_lo),
    .gp_hi  (gp_hi),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .lo_out (lo_out),
    .lo_oe  (lo_oe),
    .hi_out (hi_out),
    .done   (done)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk
  import xbus_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic             rd_n,
  input logic             wr_n,
  input logic [XB_DW-1:0] lo_out,
  input logic             lo_oe,
  input logic [XB_DW-1:0] hi_out,
  input logic [XB_DW-1:0] gp_hi,
  input logic             done,
  input xbus_phase_e      phase,
  input logic             wide_q
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));                                              // R7
  AST_NO_STROBE_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));                                         // R7
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                 // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase == PH_IDLE));                                    // R8
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !lo_oe);                                               // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (lo_out == $past(lo_out) && lo_oe));              // R2
  AST_NARROW_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && !wide_q) |-> (hi_out == gp_hi));            // R3
  AST_WIDE_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_ADDR && wide_q) |-> $stable(hi_out)); // R4
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ale    (ale),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .lo_out (lo_out),
  .lo_oe  (lo_oe),
  .hi_out (hi_out),
  .gp_hi  (gp_hi),
  .done   (done),
  .phase  (phase),
  .wide_q (wide_q)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  localparam int TA = 2;
  localparam int TL = 1;
  localparam int TD = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_wide = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, gp_lo = 8'h5A, gp_hi = 8'hC3, lo_in = '0;
  logic       ale, rd_n, wr_n, lo_oe, done;
  logic [7:0] lo_out, hi_out, rdata;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  logic [7:0] last_rd = 8'h00;

  always #10 clk = ~clk;

  xbus_ctrl #(.ADDR_CYC(TA), .LATCH_CYC(TL), .DATA_CYC(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .gp_lo(gp_lo), .gp_hi(gp_hi), .lo_in(lo_in), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out),
    .rdata(rdata), .done(done)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {ale, rd_n, wr_n, lo_oe, done}, 16'b01110);
    chk(req, lo_out, gp_lo);
    chk(req, hi_out, gp_hi);
  endtask

  task automatic bump();
    gp_hi = gp_hi + 8'h13;
    gp_lo = gp_lo + 8'h29;
  endtask

  task automatic run_cycle(input logic wide, input logic wr,
                           input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] rv);
    logic [7:0] hx;
    @(negedge clk);
    req_valid = 1'b1; req_wide = wide; req_write = wr;
    req_addr = addr; req_wdata = wd; lo_in = ~rv;
    @(negedge clk);
    // R9: keep requesting a different cycle while this one runs
    req_wide = ~wide; req_write = ~wr; req_addr = ~addr; req_wdata = ~wd;
    for (int i = 0; i < TA; i++) begin
      bump();
      #1;
      hx = wide ? addr[15:8] : gp_hi;
      chk("R2 addr phase", {ale, rd_n, wr_n, lo_oe, done}, 16'b11110);
      chk("R2 addr byte", lo_out, addr[7:0]);
      chk(wide ? "R4 high byte" : "R3 live high", hi_out, hx);
      @(negedge clk);
    end
    for (int i = 0; i < TL; i++) begin
      bump();
      #1;
      hx = wide ? addr[15:8] : gp_hi;
      if (i == TL - 1) req_valid = 1'b0;
      chk("R2 hold phase", {ale, rd_n, wr_n, lo_oe, done}, 16'b01110);
      chk("R2 addr held", lo_out, addr[7:0]);
      chk(wide ? "R4 high byte" : "R3 live high", hi_out, hx);
      @(negedge clk);
    end
    for (int i = 0; i < TD; i++) begin
      bump();
      if (i == TD - 1) lo_in = rv;
      #1;
      hx = wide ? addr[15:8] : gp_hi;
      chk(wide ? "R4 high byte" : "R3 live high", hi_out, hx);
      chk("R7 no ale", ale, 1'b0);
      if (wr) begin
        chk("R5 write strobe", {rd_n, wr_n, lo_oe, done}, 16'b1010);
        chk("R5 write byte", lo_out, wd);
      end else begin
        chk("R6 read strobe", {rd_n, wr_n, lo_oe, done}, 16'b0100);
      end
      @(negedge clk);
    end
    bump();
    lo_in = ~rv;
    #1;
    hx = wide ? addr[15:8] : gp_hi;
    chk("R8 done in close", {ale, rd_n, wr_n, done}, 16'b0111);
    chk(wide ? "R4 high byte" : "R3 live high", hi_out, hx);
    if (wr) begin
      chk("R5 byte held", {7'd0, lo_oe, lo_out}, {8'd1, wd});
      chk("R6 rdata kept on write", rdata, last_rd);
    end else begin
      last_rd = rv;
      chk("R6 no drive in close", lo_oe, 1'b0);
      chk("R6 captured byte", rdata, rv);
    end
    @(negedge clk);
    bump();
    #1;
    chk_idle("R8 back to idle");
    chk("R9 no extra cycle", done, 1'b0);
    chk("R6 rdata held", rdata, last_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk_idle("R1 in reset");
    chk("R1 rdata reset", rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    gp_hi = 8'h3C; gp_lo = 8'hA7;
    #1;
    chk_idle("R1 idle after reset");
    for (int w = 0; w < 2; w++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 16; k++) begin
          logic [15:0] a;
          a = (16'(k) * 16'h1111) ^ (w[0] ? 16'hA5C3 : 16'h0000) ^ 16'(d * 16'h0F0F);
          run_cycle(w[0], d[0], a, 8'(k * 37 + d * 5 + 3), 8'(k * 53 + w * 11 + 7));
        end
      end
    end
    // R10 and R8: cycle length from acceptance to done equals TA+TL+TD+1
    @(negedge clk);
    req_valid = 1'b1; req_wide = 1'b1; req_write = 1'b1;
    req_addr = 16'h1234; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      int n;
      n = 1;
      while (!done && n < 50) begin @(negedge clk); n++; end
      chk("R10 cycle length", 16'(n), 16'(TA + TL + TD + 1));
    end
    @(negedge clk);
    #1;
    chk_idle("R1 idle at end");
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule